// File: doc/BRIEF.md
# Packed Ternary Row Eliminator

This block carries out the row-elimination half of a simplex pivot on a tableau held in an external memory. Each tableau element is a 2-bit signed ternary value, and each memory address holds 32 of them. Each address returns as two 32-bit beats of 16 elements each. A row spans `ADDRS_PER_ROW` consecutive addresses.

After a start pulse, the block latches the pivot row index and the pivot-column entry of every row. It reads the pivot row into a local buffer. It then visits every other row whose pivot-column entry is nonzero, in ascending order. For each such row it subtracts the pivot row scaled by that entry and writes the result back. The pivot element is +1 by construction, so no normalisation, multiplier or divider is needed. All 32 lanes of an address are updated in the same cycle.

Reads are issued back to back, every other cycle, without waiting for data. The block works for any read latency because it follows the memory's valid strobe.

The controller has five states:
- `ST_IDLE` moves to `ST_LOAD` on `start`.
- `ST_LOAD` moves to `ST_ELIM` on the final pivot-row beat when some row needs work. If no row needs work, it moves straight to `ST_FIN`.
- `ST_ELIM` moves to `ST_FLUSH` on the final beat of the last row.
- `ST_FLUSH` moves to `ST_FIN` unconditionally.
- `ST_FIN` returns to `ST_IDLE`.

Top module: `tern_row_elim`

## Requirements
- R1: Lane encoding is 2-bit two's complement: 2'b00 = 0, 2'b01 = +1, 2'b11 = -1 and 2'b10 = -2. For a row with pivot-column entry a, each written lane equals x - a*p, truncated to its low two bits. Here x is the row's lane and p is the pivot row's lane at the same position.
- R2: A row whose pivot-column entry is 2'b00 is never written, and its memory contents are unchanged.
- R3: The pivot row is never written.
- R4: The pivot row is read first. Writes then occur in strictly ascending address order within one run.
- R5: Row r occupies addresses r*ADDRS_PER_ROW to r*ADDRS_PER_ROW+ADDRS_PER_ROW-1. Each read returns two beats: the first beat carries lanes 0-15 and the second carries lanes 16-31. Lane k sits at bits 2k+1:2k of the 64-bit write word.
- R6: `rd_en` is never high on two consecutive cycles.
- R7: `err` goes high when any written lane's result falls outside -1..+1. It stays high until the next accepted `start` clears it.
- R8: `done` is a one-cycle pulse in the cycle after the final write. If no row is eligible, `done` pulses with no write at all. Exactly one write occurs per address of each eligible row.
- R9: After reset, `rd_en`, `wr_en`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass; accepted only when idle |
| pivot_row | input | $clog2(ROWS) | Index of the pivot row |
| col_vals | input | 2*ROWS | Pivot-column entry of each row; row r at bits 2r+1:2r |
| rd_en | output | 1 | Read request |
| rd_addr | output | $clog2(ROWS*ADDRS_PER_ROW) | Read address |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | 32 | Read data beat (low lanes first) |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | $clog2(ROWS*ADDRS_PER_ROW) | Write address |
| wr_data | output | 64 | Updated 32-lane word |
| done | output | 1 | Pass complete pulse |
| err | output | 1 | Sticky out-of-range result flag |

## Verification
The bench targets the following corner cases, and each one exposes a specific fault:

- **Every entry value.** Rows carry pivot-column entries of +1, -1, -2 and 0. A design that mixes up the sign handling, or that writes zero-entry rows, leaves wrong or disturbed rows in memory.
- **Out-of-range results.** One case forces results of +2, and the next case is fully in range. A flag that never sets, or that is not cleared by a fresh start, shows up as a wrong `err` value.
- **No eligible row.** A pass with nothing to eliminate must finish without any write. A design that stalls in that case trips the watchdog.
- **Lane and beat mapping.** Randomised tableaux with distinct low and high beats catch a swapped beat order.
- **Ordering and pacing.** Per-run monitors catch writes out of order and reads issued on adjacent cycles.

// File: rtl/tern_elim_pkg.sv
package tern_elim_pkg;

    localparam int BEAT_W    = 32;
    localparam int ADDR_WORD = 64;
    localparam int LANES     = ADDR_WORD / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ELIM,
        ST_FLUSH,
        ST_FIN
    } elim_state_t;

    // Returns {overflow, lane result}. Scaling by the entry is done with
    // add/subtract selection only.
    function automatic logic [2:0] lane_elim(input logic [1:0] x,
                                             input logic [1:0] a,
                                             input logic [1:0] p);
        logic signed [4:0] sx;
        logic signed [4:0] sp;
        logic signed [4:0] r;
        logic              ovf;
        sx = {{3{x[1]}}, x};
        sp = {{3{p[1]}}, p};
        unique case (a)
            2'b00:   r = sx;
            2'b01:   r = sx - sp;
            2'b11:   r = sx + sp;
            default: r = sx + sp + sp;
        endcase
        ovf = (r > 5'sd1) || (r < -5'sd1);
        return {ovf, r[1:0]};
    endfunction

endpackage

// File: rtl/tern_word_elim.sv
module tern_word_elim
    import tern_elim_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic [2*NLANES-1:0] row_w,
    input  logic [2*NLANES-1:0] piv_w,
    input  logic [1:0]          coef,
    output logic [2*NLANES-1:0] res_w,
    output logic                ovf
);

    logic [NLANES-1:0] lane_ovf;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign {lane_ovf[g], res_w[2*g +: 2]} =
            lane_elim(row_w[2*g +: 2], coef, piv_w[2*g +: 2]);
    end

    assign ovf = |lane_ovf;

endmodule

// File: rtl/tern_row_scan.sv
module tern_row_scan #(
    parameter int ROWS = 8,
    parameter int RW   = $clog2(ROWS)
) (
    input  logic [ROWS-1:0] elig,
    input  logic [RW:0]     from,
    output logic [RW:0]     next
);

    localparam int NW = RW + 1;

    // Lowest eligible row at or above 'from'; ROWS when there is none.
    always_comb begin
        next = NW'(ROWS);
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (elig[r] && (NW'(r) >= from)) begin
                next = NW'(r);
            end
        end
    end

endmodule

// File: rtl/tern_row_elim.sv
module tern_row_elim
    import tern_elim_pkg::*;
#(
    parameter int ROWS          = 8,
    parameter int ADDRS_PER_ROW = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [$clog2(ROWS)-1:0]               pivot_row,
    input  logic [2*ROWS-1:0]                     col_vals,
    output logic                                  rd_en,
    output logic [$clog2(ROWS*ADDRS_PER_ROW)-1:0] rd_addr,
    input  logic                                  rd_valid,
    input  logic [31:0]                           rd_data,
    output logic                                  wr_en,
    output logic [$clog2(ROWS*ADDRS_PER_ROW)-1:0] wr_addr,
    output logic [63:0]                           wr_data,
    output logic                                  done,
    output logic                                  err
);

    localparam int RW     = $clog2(ROWS);
    localparam int NW     = RW + 1;
    localparam int AW     = $clog2(ROWS * ADDRS_PER_ROW);
    localparam int AIW    = (ADDRS_PER_ROW > 1) ? $clog2(ADDRS_PER_ROW) : 1;
    localparam logic [AIW-1:0] A_LAST = AIW'(ADDRS_PER_ROW - 1);
    localparam logic [NW-1:0]  NONE   = NW'(ROWS);

    elim_state_t state_q, state_d;

    logic [RW-1:0]       piv_q;
    logic [2*ROWS-1:0]   coef_q;
    logic [ROWS-1:0]     elig;
    logic [NW-1:0]       iss_row, ret_row, iss_next, ret_next, iss_from, issue_row;
    logic [AIW-1:0]      iss_a, ret_a;
    logic                iss_end, iss_gap, beat;
    logic [BEAT_W-1:0]   lo_q;
    logic [ADDR_WORD-1:0] pbuf [ADDRS_PER_ROW];
    logic [1:0]          cur_coef;
    logic [ADDR_WORD-1:0] elim_res;
    logic                elim_ovf;
    logic                active, ret_hi, load_last, elim_last;

    // Eligible rows: nonzero entry and not the pivot row.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            elig[r] = (coef_q[2*r +: 2] != 2'b00) && (RW'(r) != piv_q);
        end
    end

    assign iss_from  = (state_q == ST_ELIM) ? iss_row + NW'(1) : '0;
    assign issue_row = (state_q == ST_LOAD) ? {1'b0, piv_q} : iss_row;

    tern_row_scan #(.ROWS(ROWS), .RW(RW)) u_iss_scan (
        .elig (elig),
        .from (iss_from),
        .next (iss_next)
    );

    tern_row_scan #(.ROWS(ROWS), .RW(RW)) u_ret_scan (
        .elig (elig),
        .from (ret_row + NW'(1)),
        .next (ret_next)
    );

    assign cur_coef = coef_q[2*int'(ret_row[RW-1:0]) +: 2];

    tern_word_elim #(.NLANES(LANES)) u_word (
        .row_w (({rd_data, lo_q})),
        .piv_w (pbuf[ret_a]),
        .coef  (cur_coef),
        .res_w (elim_res),
        .ovf   (elim_ovf)
    );

    assign active    = (state_q == ST_LOAD) || (state_q == ST_ELIM);
    assign ret_hi    = rd_valid && beat;
    assign load_last = (state_q == ST_LOAD) && ret_hi && (ret_a == A_LAST);
    assign elim_last = (state_q == ST_ELIM) && ret_hi && (ret_a == A_LAST)
                       && (ret_next == NONE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  if (load_last) state_d = (iss_next == NONE) ? ST_FIN : ST_ELIM;
            ST_ELIM:  if (elim_last) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        done = (state_q == ST_FIN);
    end

    // Issue / return datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            piv_q   <= '0;
            coef_q  <= '0;
            iss_row <= '0;
            ret_row <= '0;
            iss_a   <= '0;
            ret_a   <= '0;
            iss_end <= 1'b0;
            iss_gap <= 1'b0;
            beat    <= 1'b0;
            rd_en   <= 1'b0;
            rd_addr <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            err     <= 1'b0;
        end else begin
            rd_en <= 1'b0;
            wr_en <= 1'b0;

            if (state_q == ST_IDLE && start) begin
                piv_q   <= pivot_row;
                coef_q  <= col_vals;
                err     <= 1'b0;
                iss_a   <= '0;
                ret_a   <= '0;
                iss_end <= 1'b0;
                beat    <= 1'b0;
            end

            // Read issue: one request every other cycle, no wait for data.
            if (active && !iss_end && !iss_gap) begin
                rd_en   <= 1'b1;
                rd_addr <= AW'(int'(issue_row) * ADDRS_PER_ROW + int'(iss_a));
                iss_gap <= 1'b1;
                if (iss_a == A_LAST) begin
                    iss_a <= '0;
                    if (state_q == ST_LOAD) begin
                        iss_end <= 1'b1;
                    end else begin
                        iss_row <= iss_next;
                        if (iss_next == NONE) iss_end <= 1'b1;
                    end
                end else begin
                    iss_a <= iss_a + AIW'(1);
                end
            end else begin
                iss_gap <= 1'b0;
            end

            // Data return: two beats per address.
            if (active && rd_valid) begin
                if (!beat) begin
                    beat <= 1'b1;
                end else begin
                    beat <= 1'b0;
                    if (state_q == ST_ELIM) begin
                        wr_en   <= 1'b1;
                        wr_addr <= AW'(int'(ret_row) * ADDRS_PER_ROW + int'(ret_a));
                        wr_data <= elim_res;
                        err     <= err | elim_ovf;
                    end
                    if (ret_a == A_LAST) begin
                        ret_a <= '0;
                        if (state_q == ST_ELIM) ret_row <= ret_next;
                    end else begin
                        ret_a <= ret_a + AIW'(1);
                    end
                end
            end

            // Pivot row buffered: arm both cursors on the first eligible row.
            if (load_last && iss_next != NONE) begin
                iss_row <= iss_next;
                ret_row <= iss_next;
                iss_a   <= '0;
                ret_a   <= '0;
                iss_end <= 1'b0;
                iss_gap <= 1'b0;
            end
        end
    end

    // Beat holding register and pivot row buffer (no reset needed)
    always_ff @(posedge clk) begin
        if (rd_valid && !beat) lo_q <= rd_data;
        if (state_q == ST_LOAD && rd_valid && beat) pbuf[ret_a] <= {rd_data, lo_q};
    end

endmodule

// File: rtl/tern_row_elim_chk.sv
module tern_row_elim_chk #(
    parameter int ROWS          = 8,
    parameter int ADDRS_PER_ROW = 2
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  start,
    input logic                                  rd_en,
    input logic                                  wr_en,
    input logic [$clog2(ROWS*ADDRS_PER_ROW)-1:0] wr_addr,
    input logic                                  done,
    input logic                                  err,
    input logic [$clog2(ROWS)-1:0]               piv_q
);

    // R6: reads are spaced at least one idle cycle apart
    a_r6_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: all writes have finished when done is raised
    a_r8_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    // R3: no write lands in the pivot row
    a_r3_pivot_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) / ADDRS_PER_ROW) != int'(piv_q));

    // R7: error flag holds until a start
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

endmodule

bind tern_row_elim tern_row_elim_chk #(
    .ROWS          (ROWS),
    .ADDRS_PER_ROW (ADDRS_PER_ROW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .done    (done),
    .err     (err),
    .piv_q   (piv_q)
);

// File: tb/tern_row_elim_test.sv
`timescale 1ns/1ps
module tern_row_elim_test;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS       = 8;
    localparam int APR        = 2;
    localparam int NADDR      = ROWS * APR;
    localparam int AW         = $clog2(NADDR);
    localparam int MEM_LAT    = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        pivot_row = '0;
    logic [2*ROWS-1:0] col_vals = '0;
    logic              rd_en, rd_valid, wr_en, done, err;
    logic [AW-1:0]     rd_addr, wr_addr;
    logic [31:0]       rd_data;
    logic [63:0]       wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    tern_row_elim #(.ROWS(ROWS), .ADDRS_PER_ROW(APR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pivot_row(pivot_row),
        .col_vals(col_vals), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .err(err)
    );

    // ---------------- memory model ----------------
    logic [63:0]   mem  [NADDR];
    logic [63:0]   img  [NADDR];
    logic [63:0]   expm [NADDR];
    logic [1:0]    cf_t [ROWS];
    logic          ld = 1'b0;
    logic          dv [MEM_LAT];
    logic [AW-1:0] da [MEM_LAT];
    logic          hi_pend;
    logic [AW-1:0] hi_a;

    always @(posedge clk) begin
        if (ld) begin
            for (int i = 0; i < NADDR; i++) mem[i] <= img[i];
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_LAT; i++) begin dv[i] <= 1'b0; da[i] <= '0; end
            rd_valid <= 1'b0; rd_data <= '0; hi_pend <= 1'b0; hi_a <= '0;
        end else begin
            dv[0] <= rd_en; da[0] <= rd_addr;
            for (int i = 1; i < MEM_LAT; i++) begin dv[i] <= dv[i-1]; da[i] <= da[i-1]; end
            if (dv[MEM_LAT-1]) begin
                rd_valid <= 1'b1; rd_data <= mem[da[MEM_LAT-1]][31:0];
                hi_pend <= 1'b1;  hi_a <= da[MEM_LAT-1];
            end else if (hi_pend) begin
                rd_valid <= 1'b1; rd_data <= mem[hi_a][63:32]; hi_pend <= 1'b0;
            end else begin
                rd_valid <= 1'b0;
            end
        end
    end

    // ---------------- port monitors ----------------
    int            wr_total = 0, order_bad = 0, spacing_bad = 0;
    logic          seen = 1'b0, rd_prev = 1'b0;
    logic [AW-1:0] last_wa = '0;

    always @(posedge clk) begin
        if (start) seen <= 1'b0;
        if (wr_en) begin
            wr_total <= wr_total + 1;
            if (seen && wr_addr <= last_wa) order_bad <= order_bad + 1;
            seen <= 1'b1;
            last_wa <= wr_addr;
        end
        if (rd_en && rd_prev) spacing_bad <= spacing_bad + 1;
        rd_prev <= rd_en;
    end

    // ---------------- checking ----------------
    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int dec(input logic [1:0] v);
        case (v)
            2'b01:   return 1;
            2'b11:   return -1;
            2'b10:   return -2;
            default: return 0;
        endcase
    endfunction

    // {overflow, word}: row word minus entry times pivot word, per lane
    function automatic logic [64:0] elim_word(input logic [63:0] x,
                                              input logic [63:0] p,
                                              input logic [1:0]  a);
        logic [63:0] w;
        logic        o;
        o = 1'b0;
        for (int k = 0; k < 32; k++) begin
            int r;
            r = dec(x[2*k +: 2]) - dec(a) * dec(p[2*k +: 2]);
            if (r > 1 || r < -1) o = 1'b1;
            w[2*k +: 2] = 2'(r);
        end
        return {o, w};
    endfunction

    function automatic logic [1:0] rnd_tern();
        int s;
        s = int'($urandom_range(0, 2));
        return (s == 0) ? 2'b00 : (s == 1) ? 2'b01 : 2'b11;
    endfunction

    task automatic run_case(input string tag, input int piv);
        int   exp_writes, ob0, wt0, sb0, cyc;
        logic exp_err;
        exp_writes = 0;
        exp_err = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            for (int a = 0; a < APR; a++) begin
                int idx;
                idx = r * APR + a;
                if (r == piv || cf_t[r] == 2'b00) begin
                    expm[idx] = img[idx];
                end else begin
                    logic [64:0] t;
                    t = elim_word(img[idx], img[piv * APR + a], cf_t[r]);
                    expm[idx] = t[63:0];
                    exp_err |= t[64];
                    exp_writes++;
                end
            end
        end
        @(negedge clk) ld = 1'b1;
        @(negedge clk) ld = 1'b0;
        ob0 = order_bad; wt0 = wr_total; sb0 = spacing_bad;
        start = 1'b1;
        pivot_row = 3'(piv);
        for (int r = 0; r < ROWS; r++) col_vals[2*r +: 2] = cf_t[r];
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R8", {tag, " watchdog: done never seen"}, 64'(done), 64'd1);
        @(negedge clk);
        chk(done == 1'b0, "R8", {tag, " done pulse width"}, 64'(done), 64'd0);
        for (int r = 0; r < ROWS; r++) begin
            for (int a = 0; a < APR; a++) begin
                string rq;
                rq = (r == piv) ? "R3" : (cf_t[r] == 2'b00) ? "R2" : "R1/R5";
                chk(mem[r*APR+a] === expm[r*APR+a], rq,
                    $sformatf("%s row %0d addr %0d", tag, r, a),
                    mem[r*APR+a], expm[r*APR+a]);
            end
        end
        chk(err == exp_err, "R7", {tag, " error flag"}, 64'(err), 64'(exp_err));
        chk(wr_total - wt0 == exp_writes, "R8", {tag, " write count"},
            64'(wr_total - wt0), 64'(exp_writes));
        chk(order_bad == ob0, "R4", {tag, " ascending write order"},
            64'(order_bad - ob0), 64'd0);
        chk(spacing_bad == sb0, "R6", {tag, " read spacing"},
            64'(spacing_bad - sb0), 64'd0);
    endtask

    task automatic rand_img();
        for (int i = 0; i < NADDR; i++) begin
            for (int k = 0; k < 32; k++) img[i][2*k +: 2] = rnd_tern();
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0421));

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(rd_en == 1'b0, "R9", "rd_en after reset", 64'(rd_en), 64'd0);
        chk(wr_en == 1'b0, "R9", "wr_en after reset", 64'(wr_en), 64'd0);
        chk(done == 1'b0, "R9", "done after reset", 64'(done), 64'd0);
        chk(err == 1'b0, "R9", "err after reset", 64'(err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R5: every entry value, random tableau, pivot row 2
        rand_img();
        for (int r = 0; r < ROWS; r++) cf_t[r] = 2'b00;
        cf_t[0] = 2'b01; cf_t[2] = 2'b01; cf_t[3] = 2'b11;
        cf_t[5] = 2'b10; cf_t[7] = 2'b01;
        run_case("D1 mixed entries", 2);

        // R8: no eligible row; only the pivot row has a nonzero entry
        rand_img();
        for (int r = 0; r < ROWS; r++) cf_t[r] = 2'b00;
        cf_t[4] = 2'b01;
        run_case("D2 nothing to do", 4);

        // R7: forced overflow, +1 - (-1)(+1) = +2 in every lane of row 1
        rand_img();
        for (int i = 0; i < NADDR; i++) img[i] = {32{2'b01}};
        for (int r = 0; r < ROWS; r++) cf_t[r] = 2'b00;
        cf_t[0] = 2'b01; cf_t[1] = 2'b11;
        run_case("D3 overflow", 0);

        // R7: clean pass clears the flag; pivot row all zero keeps rows as is
        rand_img();
        img[6*APR] = '0;
        img[6*APR+1] = '0;
        for (int r = 0; r < ROWS; r++) cf_t[r] = 2'b11;
        cf_t[6] = 2'b01;
        run_case("D4 clear flag", 6);

        // R4: last row is the pivot, every other row eligible
        rand_img();
        for (int r = 0; r < ROWS; r++) cf_t[r] = 2'b01;
        run_case("D5 pivot last", ROWS - 1);

        // Constrained random passes
        for (int n = 0; n < 8; n++) begin
            rand_img();
            for (int r = 0; r < ROWS; r++) cf_t[r] = rnd_tern();
            run_case($sformatf("RND%0d", n), int'($urandom_range(0, ROWS - 1)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule